// File: doc/BRIEF.md
# Remappable Shift-Register FIFO

This block is a first-in first-out queue of fixed depth whose storage is a row of registers that moves toward the head on every pop. Every stored word can be seen at the same time, so the block also takes a remap command: a match value and a replacement value. In one clock cycle, every occupied slot that holds the match value is overwritten with the replacement. Remaps issued in later cycles see the words as already rewritten, so a chain of remaps composes in order. The read side only selects the head slot and never translates a word on the way out.

Words enter through a valid/ready push port and leave through a valid/ready pop port. The push side is ready when the queue is not full, or when a pop is taken in the same cycle. So a full queue can take one word in and send one word out on every clock. A pop is taken only while `out_valid` is high. `in_ready` depends combinationally on `out_ready`. A push offered while the queue is full and no pop is taken is dropped, and `overflow` is high for the next cycle. Reset is active low and synchronous, and it empties the queue.

Top module: `remap_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue empties. After that edge, `count`=0, `empty`=1, `full`=0, `out_valid`=0 and `overflow`=0.
- R2: Words pop in push order. While `out_valid` is high, `out_data` is the oldest stored word. It changes only on a pop or a remap.
- R3: In a cycle with `rm_strobe` high, every occupied slot equal to `rm_match` takes `rm_repl` from the next cycle on. Slots with other values keep them.
- R4: Remaps in successive cycles compose. A word pushed as 5, then remapped 5→6 and later 6→7, pops as 7.
- R5: A word pushed in the same cycle as a remap is stored unmodified, even when it equals `rm_match`. The older words are remapped.
- R6: A word popped in the same cycle as a remap is the value from before the remap. The words that remain are remapped.
- R7: `count` holds the number of stored words and `full` is high at DEPTH. `in_ready` is `!full || out_ready`. With push and pop together at full, `count` stays DEPTH and the order is kept.
- R8: A push while full with `out_ready` low is dropped. `overflow` is high for exactly the next cycle, and the contents and count do not change.
- R9: While empty, `out_valid` is low, and `out_ready` changes nothing. `count` stays 0.
- R10: A remap whose `rm_match` equals `rm_repl` leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Push word offered |
| in_ready | output | 1 | Push will be taken this cycle |
| in_data | input | DATA_W | Push word |
| out_valid | output | 1 | Head word present |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | DATA_W | Head word |
| rm_strobe | input | 1 | Apply a remap this cycle |
| rm_match | input | DATA_W | Value to replace |
| rm_repl | input | DATA_W | Replacement value |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No word stored |
| count | output | $clog2(DEPTH+1) | Number of stored words |
| overflow | output | 1 | A push was dropped in the previous cycle |

## Verification
The remap is tried in several patterns, and each one separates a different wrong behaviour.
- A lone remap on a short queue tests the basic rewrite.
- A chain of two remaps on the same word tests composition.
- A remap in the same cycle as a push shows whether the new word is kept raw.
- A remap in the same cycle as a pop shows that the head leaves with its old value while the rest are rewritten.
- An identity remap shows that it changes nothing.
- A remap on a full queue, after steady push-with-pop flow, checks that a single slot deep inside the row is rewritten and its neighbours are not.
- Pops on an empty queue, a dropped push at full, and a reset with words inside cover the edges of the count.

// File: rtl/remap_fifo_pkg.sv
package remap_fifo_pkg;
  // per-slot control decoded once by the top
  typedef struct packed {
    logic shift;  // head popped: take the upper neighbour
    logic load;   // this slot receives the pushed word
  } slot_ctl_t;
endpackage

// File: rtl/remap_fifo_slot.sv
module remap_fifo_slot
  import remap_fifo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_ctl_t         ctl,
  input  logic              occ_self,
  input  logic              occ_up,
  input  logic [DATA_W-1:0] up_q,
  input  logic [DATA_W-1:0] push_data,
  input  logic              rm_strobe,
  input  logic [DATA_W-1:0] rm_match,
  input  logic [DATA_W-1:0] rm_repl,
  output logic [DATA_W-1:0] val_q
);
  logic [DATA_W-1:0] src, nxt;
  logic              src_occ;

  // one comparator per slot, placed after the shift mux
  always_comb begin
    src     = ctl.shift ? up_q   : val_q;
    src_occ = ctl.shift ? occ_up : occ_self;
    if (ctl.load)
      nxt = push_data;
    else if (!src_occ)
      nxt = val_q;
    else if (rm_strobe && (src == rm_match))
      nxt = rm_repl;
    else
      nxt = src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= nxt;
  end

  AST_PUSH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> val_q == $past(push_data)); // R5
endmodule

// File: rtl/remap_fifo_ctrl.sv
module remap_fifo_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             full,
  output logic             empty,
  output logic             do_push,
  output logic             do_pop,
  output logic [CNT_W-1:0] wr_idx,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

  assign full      = (count == MAXC);
  assign empty     = (count == '0);
  assign out_valid = !empty;
  assign in_ready  = !full || out_ready;
  assign do_pop    = out_valid && out_ready;
  assign do_push   = in_valid && in_ready;
  assign wr_idx    = do_pop ? count - 1'b1 : count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= in_valid && !in_ready;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> overflow); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> count == $past(count)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> empty); // R9
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> count == $past(count) - 1'b1); // R7
endmodule

// File: rtl/remap_fifo.sv
module remap_fifo
  import remap_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              rm_strobe,
  input  logic [DATA_W-1:0] rm_match,
  input  logic [DATA_W-1:0] rm_repl,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  logic             do_push, do_pop;
  logic [CNT_W-1:0] wr_idx;
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  occ;

  remap_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .full(full), .empty(empty),
    .do_push(do_push), .do_pop(do_pop), .wr_idx(wr_idx), .count(count),
    .overflow(overflow)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_ctl_t         ctl;
    logic              up_occ;
    logic [DATA_W-1:0] up_val;

    assign occ[i]    = (CNT_W'(i) < count);
    assign ctl.shift = do_pop;
    assign ctl.load  = do_push && (wr_idx == CNT_W'(i));

    if (i == DEPTH-1) begin : g_top
      assign up_occ = 1'b0;
      assign up_val = '0;
    end else begin : g_mid
      assign up_occ = occ[i+1];
      assign up_val = slot_q[i+1];
    end

    remap_fifo_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .occ_self(occ[i]),
      .occ_up(up_occ), .up_q(up_val), .push_data(in_data),
      .rm_strobe(rm_strobe), .rm_match(rm_match), .rm_repl(rm_repl),
      .val_q(slot_q[i])
    );
  end

  assign out_data = slot_q[0];

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rm_strobe) |=> out_data == $past(out_data)); // R2
  AST_HEAD_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && rm_strobe && out_data == rm_match)
      |=> out_data == $past(rm_repl)); // R3
endmodule

// File: tb/remap_fifo_bench.sv
module remap_fifo_bench;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int CW = $clog2(DP+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, rm_strobe = 1'b0;
  logic [DW-1:0] in_data = '0, rm_match = '0, rm_repl = '0;
  logic in_ready, out_valid, full, empty, overflow;
  logic [DW-1:0] out_data;
  logic [CW-1:0] count;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] q [$];

  always #2 clk = ~clk;

  remap_fifo #(.DATA_W(DW), .DEPTH(DP)) u_remap_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .rm_strobe(rm_strobe), .rm_match(rm_match),
    .rm_repl(rm_repl), .full(full), .empty(empty), .count(count),
    .overflow(overflow)
  );

  typedef struct packed {
    logic          iv;
    logic [DW-1:0] id;
    logic          ordy;
    logic          rs;
    logic [DW-1:0] rm;
    logic [DW-1:0] rr;
    logic [CW-1:0] ecnt;
    logic          eov;
    logic [DW-1:0] eod;
  } vec_t;

  // expected fields describe the state seen before the vector's inputs apply
  localparam vec_t TBL [0:10] = '{
    '{1'b1, 8'd5, 1'b0, 1'b0, 8'd0, 8'd0, 5'd0, 1'b0, 8'd0},
    '{1'b1, 8'd3, 1'b0, 1'b0, 8'd0, 8'd0, 5'd1, 1'b1, 8'd5},
    '{1'b1, 8'd5, 1'b0, 1'b1, 8'd5, 8'd6, 5'd2, 1'b1, 8'd5},
    '{1'b0, 8'd0, 1'b0, 1'b1, 8'd6, 8'd7, 5'd3, 1'b1, 8'd6},
    '{1'b0, 8'd0, 1'b0, 1'b1, 8'd3, 8'd3, 5'd3, 1'b1, 8'd7},
    '{1'b0, 8'd0, 1'b1, 1'b1, 8'd5, 8'd8, 5'd3, 1'b1, 8'd7},
    '{1'b0, 8'd0, 1'b1, 1'b0, 8'd0, 8'd0, 5'd2, 1'b1, 8'd3},
    '{1'b1, 8'd4, 1'b1, 1'b0, 8'd0, 8'd0, 5'd1, 1'b1, 8'd8},
    '{1'b0, 8'd0, 1'b1, 1'b0, 8'd0, 8'd0, 5'd1, 1'b1, 8'd4},
    '{1'b0, 8'd0, 1'b1, 1'b0, 8'd0, 8'd0, 5'd0, 1'b0, 8'd0},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'd0, 5'd0, 1'b0, 8'd0}
  };

  function automatic string tag_of(int k);
    case (k)
      3:       return "R3 R5";
      4:       return "R4";
      5:       return "R10";
      6:       return "R6";
      10:      return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 overflow", overflow, 0);
    rst_n = 1'b1;

    for (int k = 0; k <= 10; k++) begin
      chk(tag_of(k), count, TBL[k].ecnt);
      chk(tag_of(k), out_valid, TBL[k].eov);
      if (TBL[k].eov) chk(tag_of(k), out_data, TBL[k].eod);
      in_valid  = TBL[k].iv;
      in_data   = TBL[k].id;
      out_ready = TBL[k].ordy;
      rm_strobe = TBL[k].rs;
      rm_match  = TBL[k].rm;
      rm_repl   = TBL[k].rr;
      tick();
    end
    in_valid = 0; out_ready = 0; rm_strobe = 0;

    // R7 fill to DEPTH
    for (int i = 0; i < DP; i++) begin
      in_valid = 1; in_data = DW'(3 * i); q.push_back(DW'(3 * i));
      tick();
    end
    in_valid = 0;
    chk("R7 count", count, DP);
    chk("R7 full", full, 1);
    chk("R7 in_ready low", in_ready, 0);
    out_ready = 1; #1;
    chk("R7 in_ready high", in_ready, 1);
    out_ready = 0; #1;

    // R8 dropped push
    in_valid = 1; in_data = 8'hAA;
    tick();
    in_valid = 0;
    chk("R8 overflow", overflow, 1);
    chk("R8 count", count, DP);
    tick();
    chk("R8 overflow clears", overflow, 0);

    // R7 steady flow at full
    for (int j = 0; j < 4; j++) begin
      in_valid = 1; out_ready = 1; in_data = DW'(100 + j);
      chk("R7 flow head", out_data, q[0]);
      void'(q.pop_front());
      q.push_back(DW'(100 + j));
      tick();
      chk("R7 flow count", count, DP);
    end
    in_valid = 0; out_ready = 0;

    // R3 remap on full queue
    rm_strobe = 1; rm_match = 8'd30; rm_repl = 8'd200;
    foreach (q[i]) if (q[i] == 8'd30) q[i] = 8'd200;
    tick();
    rm_strobe = 0;

    for (int i = 0; i < DP; i++) begin
      out_ready = 1;
      chk("R3 R2 drain", out_data, q[i]);
      tick();
    end
    out_ready = 0;
    chk("R9 empty", empty, 1);
    chk("R9 count", count, 0);

    // R1 reset with words inside
    in_valid = 1; in_data = 8'd9;
    tick(); tick();
    in_valid = 0;
    chk("R1 pre count", count, 2);
    rst_n = 0;
    tick();
    chk("R1 reset count", count, 0);
    chk("R1 reset out_valid", out_valid, 0);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule